// File: doc/BRIEF.md
# Low-Power Compare Timer

A 32-bit memory-mapped timer whose counting logic lives in its own counter clock domain. That domain is separate from, and asynchronous to, the bus clock, so it can keep running while the bus clock is gated. Software reaches the block through a flat register port: an address, a write strobe, write data, and combinational read data.

The counter counts up. It runs once an enable bit is set and advances once every 2^N counter-clock cycles, where N is a prescale code. After it reaches a programmable limit it returns to zero. One channel compares the count against a programmed value. When the count steps onto that value, a sticky match flag is set. The interrupt output is that flag gated by a channel enable, and it is delivered in the bus domain.

Every bus write is carried into the counter domain through a toggle request/acknowledge pair. While a write is still pending, a busy bit reads as 1, and any further write is dropped. For this reason a new compare value takes effect a few counter cycles after the bus write. If the count has already moved past the new value by then, the match waits for the next wrap.

The count seen on the bus is a held snapshot, refreshed by a second handshake, so a multi-bit value is never read half-updated.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset the control, count, status, channel-control and channel-value registers read 0, the limit register reads 0xFFFFFFFF, and `irq` is 0.
- R2: Bit 3 of the control register (offset 0x10) enables counting; with it at 0 the count read at 0x14 does not change.
- R3: Bits 2:0 of the control register hold N; an enabled counter advances once per 2^N counter-clock cycles.
- R4: With limit L at offset 0x18, the count returns to zero on the tick after reaching L and is never read above L.
- R5: Any write to offset 0x14, whatever its data, sets the count to zero and restarts the prescaler.
- R6: Bit 0 of the status register (0x1C) is set when the count steps onto the channel value (0x24) while bits 5:2 of channel control (0x20) equal 4; any other mode value never sets it.
- R7: Writing 1 to status bit 0 clears the match flag; writing 0 leaves it set.
- R8: `irq` equals the match flag ANDed with channel-control bit 6, seen in the bus domain.
- R9: Status bit 1 (busy) reads 1 from an accepted write until the counter domain has applied it; a write made while busy is ignored.
- R10: Control reads back only bits 3:0 and channel control only bits 6:2 of the last accepted write; other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-port clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| cnt_clk | input | 1 | Asynchronous counter clock |
| cnt_rst_n | input | 1 | Synchronous active-low reset, counter domain |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request, bus domain |

## Verification
If the prescaler or the enable goes wrong, the snapshot count drifts away from the span of counter cycles that elapsed. That error shows within one snapshot refresh, about five counter cycles. A wrong wrap appears as a count above the limit, or as a count that never falls, within one limit period. A handshake fault shows up in two ways: the busy bit stays stuck at 1, or a write made while busy changes the readback. A lost or spurious match shows on status bit 0 and on `irq` a few bus cycles after the count reaches the channel value.

// File: rtl/lpt_pkg.sv
// Shared constants and types for the low-power compare timer.
// Assumes a 32-bit count and byte offsets decoded on 8 address bits.
package lpt_pkg;
    localparam int CNT_W = 32;
    localparam int ADR_W = 8;

    localparam logic [ADR_W-1:0] OFS_CTRL  = 8'h10;
    localparam logic [ADR_W-1:0] OFS_COUNT = 8'h14;
    localparam logic [ADR_W-1:0] OFS_LIMIT = 8'h18;
    localparam logic [ADR_W-1:0] OFS_STAT  = 8'h1C;
    localparam logic [ADR_W-1:0] OFS_CHCTL = 8'h20;
    localparam logic [ADR_W-1:0] OFS_CHVAL = 8'h24;

    localparam logic [3:0] MODE_SWCMP = 4'h4;

    typedef enum logic [2:0] {
        TG_NONE, TG_CTRL, TG_COUNT, TG_LIMIT, TG_STAT, TG_CHCTL, TG_CHVAL
    } target_e;

    typedef struct packed {
        target_e          tgt;
        logic [CNT_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/lpt_sync.sv
// Multi-stage flop synchronizer for independent single-bit signals.
// Assumes each bit is a level or a toggle that stays stable for many cycles.
module lpt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    // shift the asynchronous input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lpt_core.sv
// Counter-domain logic: applies bus writes, prescaler, up-counter with limit,
// software compare channel and count snapshot source.
// Assumes req is held stable while req_tgl_s differs from ack_tgl.
module lpt_core
    import lpt_pkg::*;
#(
    parameter int PSC_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl_s,
    input  wr_req_t          req,
    input  logic             snap_ack_s,
    output logic             ack_tgl,
    output logic             snap_tgl,
    output logic [CNT_W-1:0] snap_data,
    output logic             flag,
    output logic             irq_raw
);
    localparam int PDIV_W = (1 << PSC_BITS) - 1;

    logic                run_en;
    logic [PSC_BITS-1:0] psc;
    logic [PDIV_W-1:0]   pcnt, pmask;
    logic [CNT_W-1:0]    cnt, cnt_nxt, limit, chval;
    logic [3:0]          chmode;
    logic                chie, apply, tick, match;

    assign apply   = req_tgl_s != ack_tgl;
    assign pmask   = PDIV_W'((1 << psc) - 1);
    assign tick    = run_en && ((pcnt & pmask) == pmask);
    assign cnt_nxt = (cnt >= limit) ? '0 : cnt + 1'b1;
    assign match   = tick && (chmode == MODE_SWCMP) && (cnt_nxt == chval);

    // count, apply pending write, then set the match flag (set wins over clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0; psc <= '0; pcnt <= '0; cnt <= '0;
            limit <= '1; chval <= '0; chmode <= '0; chie <= 1'b0;
            flag <= 1'b0; ack_tgl <= 1'b0;
        end else begin
            if (run_en) pcnt <= pcnt + 1'b1;
            if (tick)   cnt  <= cnt_nxt;
            if (apply) begin
                ack_tgl <= ~ack_tgl;
                case (req.tgt)
                    TG_CTRL:  begin run_en <= req.data[3]; psc <= req.data[PSC_BITS-1:0]; end
                    TG_COUNT: begin cnt <= '0; pcnt <= '0; end
                    TG_LIMIT: limit <= req.data;
                    TG_STAT:  if (req.data[0]) flag <= 1'b0;
                    TG_CHCTL: begin chmode <= req.data[5:2]; chie <= req.data[6]; end
                    TG_CHVAL: chval <= req.data;
                    default:  ;
                endcase
            end
            if (match) flag <= 1'b1;
        end
    end

    // registered interrupt level so the synchronizer sees a glitch-free input
    always_ff @(posedge clk) begin
        if (!rst_n) irq_raw <= 1'b0;
        else        irq_raw <= flag & chie;
    end

    // capture a fresh snapshot each time the bus side has acknowledged the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_tgl  <= 1'b0;
            snap_data <= '0;
        end else if (snap_ack_s == snap_tgl) begin
            snap_tgl  <= ~snap_tgl;
            snap_data <= cnt;
        end
    end

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !apply) |=> $stable(cnt));
    a_r4_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt >= limit) |=> (cnt == '0));
    a_r6_flag_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(chmode) == MODE_SWCMP));
    a_r7_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && req.tgt == TG_STAT && req.data[0] && !match) |=> !flag);
endmodule

// File: rtl/lpt_bus.sv
// Bus-domain logic: write decode and acceptance, readback shadows, request
// toggle source, count snapshot receiver and read mux.
// Assumes the handshake inputs have already been synchronized into bus_clk.
module lpt_bus
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADR_W-1:0] addr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ack_tgl_s,
    input  logic             snap_tgl_s,
    input  logic [CNT_W-1:0] snap_data,
    input  logic             flag_s,
    output logic [CNT_W-1:0] rd_data,
    output logic             req_tgl,
    output wr_req_t          req,
    output logic             snap_ack
);
    target_e          tgt;
    logic             busy, accept;
    logic [3:0]       ctrl_sh;
    logic [4:0]       chctl_sh;
    logic [CNT_W-1:0] limit_sh, chval_sh, cnt_rd;

    // map a byte offset onto a write target
    always_comb begin
        case (addr)
            OFS_CTRL:  tgt = TG_CTRL;
            OFS_COUNT: tgt = TG_COUNT;
            OFS_LIMIT: tgt = TG_LIMIT;
            OFS_STAT:  tgt = TG_STAT;
            OFS_CHCTL: tgt = TG_CHCTL;
            OFS_CHVAL: tgt = TG_CHVAL;
            default:   tgt = TG_NONE;
        endcase
    end

    assign busy   = req_tgl != ack_tgl_s;
    assign accept = wr_en && (tgt != TG_NONE) && !busy;

    // launch a request and update readback shadows on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tgl <= 1'b0; req <= '{tgt: TG_NONE, data: '0};
            ctrl_sh <= '0; chctl_sh <= '0; limit_sh <= '1; chval_sh <= '0;
        end else if (accept) begin
            req_tgl <= ~req_tgl;
            req     <= '{tgt: tgt, data: wr_data};
            case (tgt)
                TG_CTRL:  ctrl_sh  <= wr_data[3:0];
                TG_LIMIT: limit_sh <= wr_data;
                TG_CHCTL: chctl_sh <= wr_data[6:2];
                TG_CHVAL: chval_sh <= wr_data;
                default:  ;
            endcase
        end
    end

    // take a held snapshot when its toggle arrives, then acknowledge it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ack <= 1'b0;
            cnt_rd   <= '0;
        end else if (snap_tgl_s != snap_ack) begin
            snap_ack <= snap_tgl_s;
            cnt_rd   <= snap_data;
        end
    end

    // register read mux
    always_comb begin
        case (addr)
            OFS_CTRL:  rd_data = {28'd0, ctrl_sh};
            OFS_COUNT: rd_data = cnt_rd;
            OFS_LIMIT: rd_data = limit_sh;
            OFS_STAT:  rd_data = {30'd0, busy, flag_s};
            OFS_CHCTL: rd_data = {25'd0, chctl_sh, 2'b00};
            OFS_CHVAL: rd_data = chval_sh;
            default:   rd_data = '0;
        endcase
    end

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(req_tgl) && $stable(limit_sh) && $stable(chval_sh)));
endmodule

// File: rtl/lp_cmp_timer.sv
// Top of the low-power compare timer: bus-domain block, counter-domain block
// and the synchronizers between them.
// Assumes bus_clk and cnt_clk are unrelated; each reset is synchronous to its clock.
module lp_cmp_timer
    import lpt_pkg::*;
#(
    parameter int PSC_BITS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        cnt_clk,
    input  logic        cnt_rst_n,
    input  logic [7:0]  addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq
);
    logic             req_tgl, ack_tgl, snap_tgl, snap_ack, flag, irq_raw;
    logic             req_tgl_s, snap_ack_s, ack_tgl_s, snap_tgl_s, flag_s;
    logic [CNT_W-1:0] snap_data;
    wr_req_t          req;

    lpt_bus u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .ack_tgl_s(ack_tgl_s), .snap_tgl_s(snap_tgl_s),
        .snap_data(snap_data), .flag_s(flag_s), .rd_data(rd_data),
        .req_tgl(req_tgl), .req(req), .snap_ack(snap_ack)
    );

    lpt_core #(.PSC_BITS(PSC_BITS)) u_core (
        .clk(cnt_clk), .rst_n(cnt_rst_n), .req_tgl_s(req_tgl_s), .req(req),
        .snap_ack_s(snap_ack_s), .ack_tgl(ack_tgl), .snap_tgl(snap_tgl),
        .snap_data(snap_data), .flag(flag), .irq_raw(irq_raw)
    );

    lpt_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync_bus (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .d({ack_tgl, snap_tgl, flag, irq_raw}),
        .q({ack_tgl_s, snap_tgl_s, flag_s, irq})
    );

    lpt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_cnt (
        .clk(cnt_clk), .rst_n(cnt_rst_n),
        .d({req_tgl, snap_ack}),
        .q({req_tgl_s, snap_ack_s})
    );
endmodule

// File: tb/lp_cmp_timer_tb.sv
// Self-checking bench: prescaler sweep, wrap, compare, clear, busy-drop and readback.
module lp_cmp_timer_tb;
    logic        bus_clk = 0, cnt_clk = 0, bus_rst_n = 0, cnt_rst_n = 0;
    logic [7:0]  addr = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    always #5  bus_clk = ~bus_clk;
    always #13 cnt_clk = ~cnt_clk;

    lp_cmp_timer u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cnt_clk(cnt_clk),
        .cnt_rst_n(cnt_rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk); addr = a; wr_data = d; wr_en = 1;
        @(negedge bus_clk); wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge bus_clk); addr = a; #1 d = rd_data;
    endtask

    task automatic idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            rd(8'h1C, s);
            if (!s[1]) return;
        end
        chk("R9 busy never cleared", s & 32'h2, 32'h0);
    endtask

    task automatic wr_idle(input logic [7:0] a, input logic [31:0] d);
        wr(a, d); idle();
    endtask

    task automatic cwait(input int n);
        for (int i = 0; i < n; i++) @(posedge cnt_clk);
        @(negedge bus_clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, prev;
        bit          fell;
        repeat (4) @(posedge cnt_clk);
        bus_rst_n = 1; cnt_rst_n = 1;
        cwait(12);

        // R1 reset state
        rd(8'h10, v); chk("R1 ctrl", v, 0);
        rd(8'h14, v); chk("R1 count", v, 0);
        rd(8'h18, v); chk("R1 limit", v, 32'hFFFF_FFFF);
        rd(8'h1C, v); chk("R1 status", v, 0);
        rd(8'h20, v); chk("R1 chctl", v, 0);
        rd(8'h24, v); chk("R1 chval", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R9 busy after write, second write during busy dropped
        wr(8'h18, 100);
        rd(8'h1C, v); chk("R9 busy set", v & 2, 2);
        wr(8'h18, 200);
        idle();
        rd(8'h18, v); chk("R9 write while busy ignored", v, 100);
        wr_idle(8'h18, 32'hFFFF_FFFF);

        // R3 prescaler sweep, R2 stop holds count
        for (int n = 0; n < 4; n++) begin
            wr_idle(8'h14, 0);
            wr_idle(8'h10, 8 | n);
            cwait(128);
            wr_idle(8'h10, n);
            cwait(12);
            rd(8'h14, v);
            chk_rng($sformatf("R3 count with N=%0d", n), int'(v), 128 >> n, (140 >> n) + 1);
            cwait(40);
            rd(8'h14, v2); chk("R2 stopped count stable", v2, v);
        end

        // R5 count write clears
        wr_idle(8'h14, 32'h1234_5678);
        cwait(12);
        rd(8'h14, v); chk("R5 count cleared", v, 0);

        // R4 wrap at limit 5
        wr_idle(8'h18, 5);
        wr_idle(8'h10, 8);
        prev = 0; fell = 0; v2 = 0;
        for (int i = 0; i < 60; i++) begin
            repeat (7) @(negedge bus_clk);
            rd(8'h14, v);
            if (v > v2) v2 = v;
            if (v < prev) fell = 1;
            prev = v;
        end
        chk_rng("R4 max count within limit", int'(v2), 0, 5);
        chk("R4 count wrapped", {31'd0, fell}, 1);
        wr_idle(8'h10, 0);

        // R6 + R8 match with interrupt enabled
        wr_idle(8'h14, 0);
        wr_idle(8'h18, 9);
        wr_idle(8'h24, 4);
        wr_idle(8'h20, 32'h50);
        wr_idle(8'h10, 8);
        cwait(30);
        wr_idle(8'h10, 0);
        cwait(4);
        rd(8'h1C, v); chk("R6 match flag set", v & 1, 1);
        chk("R8 irq with enable", {31'd0, irq}, 1);

        // R7 write 0 keeps, write 1 clears
        wr_idle(8'h1C, 0);
        cwait(6);
        rd(8'h1C, v); chk("R7 write 0 keeps flag", v & 1, 1);
        wr_idle(8'h1C, 1);
        cwait(6);
        rd(8'h1C, v); chk("R7 write 1 clears flag", v & 1, 0);
        chk("R8 irq drops with flag", {31'd0, irq}, 0);

        // R8 interrupt enable off
        wr_idle(8'h20, 32'h10);
        wr_idle(8'h14, 0);
        wr_idle(8'h10, 8);
        cwait(30);
        wr_idle(8'h10, 0);
        cwait(4);
        rd(8'h1C, v); chk("R8 flag set without enable", v & 1, 1);
        chk("R8 irq masked", {31'd0, irq}, 0);
        wr_idle(8'h1C, 1);

        // R6 non-compare mode never flags
        wr_idle(8'h20, 32'h60);
        wr_idle(8'h14, 0);
        wr_idle(8'h10, 8);
        cwait(40);
        wr_idle(8'h10, 0);
        cwait(4);
        rd(8'h1C, v); chk("R6 other mode no flag", v & 1, 0);
        chk("R6 other mode no irq", {31'd0, irq}, 0);

        // R10 readback masking
        wr_idle(8'h10, 32'hFFFF_FFF5);
        rd(8'h10, v); chk("R10 ctrl mask", v, 5);
        wr_idle(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R10 chctl mask", v, 32'h7C);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule